// File: doc/BRIEF.md
# Logarithmic Barrel Shifter and Rotator

This is a purely combinational shifter for a word of `WIDTH` bits. A two-bit mode input selects one of four operations: logical left, logical right, arithmetic right, or rotate right. The operation moves the word by any distance from 0 to `WIDTH-1`. An enable input gates the result; when enable is low, the output is all zeros.

The data passes through `log2(WIDTH)` multiplexer stages in a chain. Stage k is controlled by bit k of the shift amount. That stage either passes its input through unchanged or moves it by 2^k positions. A small decoder turns the mode into three controls that every stage shares: a direction, a rotate flag and a fill bit. One chain therefore serves all four operations. The block has no rotate-left mode. A rotate left by `a` is done by asking for a rotate right by `(WIDTH - a) mod WIDTH`.

Top module: `bsr_barrel`

## Requirements
- R1: With mode 2'b00 (logical left) and enable high, the output is the data moved toward the MSB by `amount` places, and the vacated low positions are 0.
- R2: With mode 2'b01 (logical right) and enable high, the output is the data moved toward the LSB by `amount` places, and the vacated high positions are 0.
- R3: With mode 2'b10 (arithmetic right) and enable high, the output is the data moved toward the LSB by `amount` places, and the vacated high positions take the MSB of the input data.
- R4: With mode 2'b11 (rotate right) and enable high, bit i of the output equals input bit (i + amount) mod WIDTH, so no bit is lost.
- R5: A rotate left by `a` is obtained with mode 2'b11 and amount (WIDTH − a) mod WIDTH.
- R6: With enable low, the output is all zeros, whatever the data, amount and mode.
- R7: With enable high and amount 0, the output equals the input data in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be shifted or rotated |
| amount | input | $clog2(WIDTH) | Distance of the move; bit k enables the 2^k stage |
| mode | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| enable | input | 1 | High to pass the result; low to force zero |
| data_out | output | WIDTH | Shifted, rotated or zeroed word |

## Verification
Several properties are checked by the assertions on every evaluation. When enable is low, the output is zero. With a zero amount, the output equals the input. A rotate keeps the population count unchanged. An arithmetic right move keeps the sign bit. A nonzero logical move leaves a zero in the vacated end bit. These properties do not show that each bit lands at the correct position, nor that the stages combine correctly for amounts with several bits set. Only the bench can show that, by sweeping every data value, amount and mode against a behavioural model. The same applies to rotate left through the complemented amount.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  typedef enum logic [1:0] {
    MODE_SHL = 2'b00,
    MODE_SHR = 2'b01,
    MODE_SAR = 2'b10,
    MODE_ROR = 2'b11
  } shift_mode_e;

  typedef struct packed {
    logic to_left;
    logic wrap;
    logic fill;
  } stage_ctrl_t;
endpackage

// File: rtl/bsr_decode.sv
`timescale 1ns/1ps
module bsr_decode
  import bsr_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic        sign_bit,
  output stage_ctrl_t ctrl
);
  shift_mode_e mode_e;

  always_comb begin
    mode_e       = shift_mode_e'(mode);
    ctrl.to_left = (mode_e == MODE_SHL);
    ctrl.wrap    = (mode_e == MODE_ROR);
    ctrl.fill    = (mode_e == MODE_SAR) && sign_bit;
  end
endmodule

// File: rtl/bsr_stage.sv
`timescale 1ns/1ps
module bsr_stage
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             move,
  input  stage_ctrl_t      ctrl,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_low;
    logic from_high;

    if (i >= DIST) begin : g_lo_in
      assign from_low = din[i-DIST];
    end else begin : g_lo_zero
      assign from_low = 1'b0;
    end

    if (i + DIST < WIDTH) begin : g_hi_in
      assign from_high = din[i+DIST];
    end else begin : g_hi_edge
      assign from_high = ctrl.wrap ? din[i+DIST-WIDTH] : ctrl.fill;
    end

    assign dout[i] = !move ? din[i] : (ctrl.to_left ? from_low : from_high);
  end
endmodule

// File: rtl/bsr_barrel.sv
`timescale 1ns/1ps
module bsr_barrel
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] amount,
  input  logic [1:0]       mode,
  input  logic             enable,
  output logic [WIDTH-1:0] data_out
);
  stage_ctrl_t      ctrl;
  logic [WIDTH-1:0] tap [AMT_W+1];

  bsr_decode u_decode (
    .mode     (mode),
    .sign_bit (data_in[WIDTH-1]),
    .ctrl     (ctrl)
  );

  assign tap[0] = data_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    bsr_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << k)
    ) u_stage (
      .din  (tap[k]),
      .move (amount[k]),
      .ctrl (ctrl),
      .dout (tap[k+1])
    );
  end

  assign data_out = enable ? tap[AMT_W] : '0;

  always_comb begin
    // R6
    gate_zero_chk: assert (enable || data_out == '0)
      else $error("enable low but output nonzero");
    // R7
    zero_amt_chk: assert (!enable || amount != '0 || data_out == data_in)
      else $error("zero amount did not pass data through");
    // R4
    rot_keep_ones_chk: assert (!enable || mode != 2'b11 ||
                               $countones(data_out) == $countones(data_in))
      else $error("rotate changed population count");
    // R3
    sar_sign_chk: assert (!enable || mode != 2'b10 || data_out[WIDTH-1] == data_in[WIDTH-1])
      else $error("arithmetic right lost sign bit");
    // R2
    shr_msb_chk: assert (!enable || mode != 2'b01 || amount == '0 || !data_out[WIDTH-1])
      else $error("logical right left a one in the MSB");
    // R1
    shl_lsb_chk: assert (!enable || mode != 2'b00 || amount == '0 || !data_out[0])
      else $error("logical left left a one in the LSB");
  end
endmodule

// File: tb/bsr_barrel_tb.sv
`timescale 1ns/1ps
module bsr_barrel_tb;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk;
  logic [W-1:0]  data_in;
  logic [AW-1:0] amount;
  logic [1:0]    mode;
  logic          enable;
  logic [W-1:0]  data_out;

  int checks;
  int errors;
  int cycles;
  bit done;

  bsr_barrel #(.WIDTH(W)) u_dut (
    .data_in  (data_in),
    .amount   (amount),
    .mode     (mode),
    .enable   (enable),
    .data_out (data_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] d,
                                         input int a);
    logic signed [W-1:0] sd;
    logic [W-1:0] r;
    sd = d;
    case (m)
      2'b00:   r = d << a;
      2'b01:   r = d >> a;
      2'b10:   r = sd >>> a;
      default: r = (a == 0) ? d : ((d >> a) | (d << (W - a)));
    endcase
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] d, input int a, input logic [1:0] m,
                       input logic en);
    @(negedge clk);
    data_in = d;
    amount  = AW'(a);
    mode    = m;
    enable  = en;
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (data_out !== exp) begin
      errors++;
      $display("FAIL %s: data=%h amt=%0d mode=%b en=%b got %h expected %h",
               tag, data_in, amount, mode, enable, data_out, exp);
    end
  endtask

  task automatic test_idle_zero();
    apply(8'hFF, 5, 2'b10, 1'b0);
    check("R6", 8'h00);
  endtask

  task automatic test_disabled();
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < W; a++) begin
        apply(8'hA5 ^ 8'(a * 37), a, 2'(m), 1'b0);
        check("R6", 8'h00);
      end
    end
  endtask

  task automatic test_zero_amount();
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 256; d += 17) begin
        apply(8'(d), 0, 2'(m), 1'b1);
        check("R7", 8'(d));
      end
    end
  endtask

  task automatic test_mode_sweep(input logic [1:0] m);
    string tag;
    case (m)
      2'b00:   tag = "R1";
      2'b01:   tag = "R2";
      2'b10:   tag = "R3";
      default: tag = "R4";
    endcase
    for (int d = 0; d < 256; d++) begin
      for (int a = 0; a < W; a++) begin
        apply(8'(d), a, m, 1'b1);
        check(tag, model(m, 8'(d), a));
      end
    end
  endtask

  task automatic test_rotate_left();
    for (int d = 0; d < 256; d += 7) begin
      for (int a = 0; a < W; a++) begin
        logic [W-1:0] exp;
        exp = (a == 0) ? 8'(d) : ((8'(d) << a) | (8'(d) >> (W - a)));
        apply(8'(d), (W - a) % W, 2'b11, 1'b1);
        check("R5", exp);
      end
    end
  endtask

  task automatic test_known_values();
    apply(8'h19, 2, 2'b00, 1'b1); check("R1", 8'h64);
    apply(8'hC8, 2, 2'b01, 1'b1); check("R2", 8'h32);
    apply(8'hC8, 2, 2'b10, 1'b1); check("R3", 8'hF2);
    apply(8'h19, 2, 2'b11, 1'b1); check("R4", 8'h46);
    apply(8'h19, 6, 2'b11, 1'b1); check("R5", 8'h64);
    apply(8'h80, 7, 2'b10, 1'b1); check("R3", 8'hFF);
    apply(8'h80, 7, 2'b01, 1'b1); check("R2", 8'h01);
    apply(8'h01, 7, 2'b00, 1'b1); check("R1", 8'h80);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    data_in = '0;
    amount  = '0;
    mode    = 2'b00;
    enable  = 1'b0;
    test_idle_zero();
    test_known_values();
    test_disabled();
    test_zero_amount();
    for (int m = 0; m < 4; m++) test_mode_sweep(2'(m));
    test_rotate_left();
    finish_run();
  end
endmodule